// File: doc/BRIEF.md
# Flash Timing Clock Divider

This block derives a slow timing strobe for a flash program/erase sequencer from the system clock. Software writes one 8-bit configuration register. That register holds a 6-bit divide field in bits [5:0] and a prescaler-select bit in bit 6. When bit 6 is set, a fixed divide-by-8 stage runs in front of a divide-by-(field+1) counter. The output is a strobe one system clock wide, not a generated clock, so the whole design stays in one clock domain. Sequencers elsewhere count these strobes, and their timing therefore stretches in proportion to the programmed period. For example, writing 0x54 gives a period of 8 × 21 = 168 system clocks.

Any write to the register sets a sticky "configured" flag. Reads return this flag in bit 7. While the flag is clear, the strobe stays quiet and every command-launch request is refused. A launch is also refused when the command buffer is not empty. A refused launch produces a one-cycle error pulse. A granted launch produces a one-cycle accept pulse.

Top module: `flash_tick_divider`

## Requirements
- R1: After reset, `cfg_loaded` is 0, `cfg_rd_data` is 0x00, and `tick`, `cmd_accept` and `acc_err` are all 0.
- R2: Any write sets `cfg_loaded` at the write's clock edge, and it stays 1 until reset. `cfg_rd_data[7]` always equals `cfg_loaded`.
- R3: `cfg_rd_data[6:0]` returns bits [6:0] of the last write. Bit 7 of the write data is ignored.
- R4: With the last written value v, `tick` is high for exactly one cycle in every N cycles, where N = (1 + 7·v[6]) × (v[5:0] + 1).
- R5: A write restarts the divider. `tick` is 0 in the cycle after the write edge. The first tick at the new rate is sampled N cycles after the write edge.
- R6: While `cfg_loaded` is 0, `tick` stays 0.
- R7: A `cmd_launch` sampled while `cfg_loaded` = 1 and `buf_empty` = 1 produces `cmd_accept` = 1 and `acc_err` = 0 in the next cycle.
- R8: A `cmd_launch` sampled while `cfg_loaded` = 0 produces `acc_err` = 1 and `cmd_accept` = 0 in the next cycle.
- R9: A `cmd_launch` sampled while `buf_empty` = 0 produces `acc_err` = 1 and `cmd_accept` = 0 in the next cycle.
- R10: A cycle without `cmd_launch` is followed by `cmd_accept` = 0 and `acc_err` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the divider register |
| cfg_wr_data | input | 8 | Write data: [5:0] divide field, [6] prescaler select, [7] ignored |
| cfg_rd_data | output | 8 | Read data: {configured flag, prescaler select, divide field} |
| cfg_loaded | output | 1 | Register has been written since reset |
| tick | output | 1 | One-cycle timing strobe at the divided rate |
| cmd_launch | input | 1 | Request to launch a program/erase command |
| buf_empty | input | 1 | Command buffer empty flag |
| cmd_accept | output | 1 | One-cycle pulse: launch granted |
| acc_err | output | 1 | One-cycle pulse: launch refused |

## Verification
A wrong prescaler or counter state shows up as a tick that lands early or late. This becomes visible within one programmed period, at most 512 cycles after a write. A counter that a write fails to clear shifts the first tick after the write, so the bench checks the tick on every cycle of two full periods after each write. A corrupted configured flag shows up within one cycle as a wrong bit 7 of the read data and as an accept or error pulse of the wrong kind on the next launch.

// File: rtl/fd_pkg.sv
package fd_pkg;
   localparam int unsigned DIV_BITS = 6;

   typedef struct packed {
      logic                pre_sel;
      logic [DIV_BITS-1:0] div;
   } fd_cfg_t;
endpackage

// File: rtl/fd_cfg_reg.sv
module fd_cfg_reg
   import fd_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wr_en,
   input  fd_cfg_t wr_cfg,
   output fd_cfg_t cfg,
   output logic    loaded
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= '0;
         loaded <= 1'b0;
      end else if (wr_en) begin
         cfg    <= wr_cfg;
         loaded <= 1'b1;
      end
   end
endmodule

// File: rtl/fd_prescaler.sv
module fd_prescaler #(
   parameter int unsigned PRE_RATIO = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic pre_sel,
   output logic stb
);
   generate
      if (PRE_RATIO < 1) begin : g_bad_ratio
         $error("fd_prescaler: PRE_RATIO must be at least 1");
      end

      if (PRE_RATIO > 1) begin : g_div
         localparam int unsigned CW = $clog2(PRE_RATIO);
         localparam logic [CW-1:0] LAST = CW'(PRE_RATIO - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (clear || !run || !pre_sel) begin
               cnt <= '0;
            end else if (cnt == LAST) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         assign stb = run && (!pre_sel || (cnt == LAST));
      end else begin : g_pass
         assign stb = run;
      end
   endgenerate
endmodule

// File: rtl/fd_main_count.sv
module fd_main_count #(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             stb,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (clear) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (stb) begin
         if (cnt == div) begin
            cnt  <= '0;
            tick <= 1'b1;
         end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
         end
      end else begin
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/fd_launch_gate.sv
module fd_launch_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic loaded,
   input  logic buf_empty,
   output logic accept,
   output logic err
);
   logic ok;
   assign ok = loaded && buf_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accept <= 1'b0;
         err    <= 1'b0;
      end else begin
         accept <= launch && ok;
         err    <= launch && !ok;
      end
   end
endmodule

// File: rtl/flash_tick_divider.sv
module flash_tick_divider
   import fd_pkg::*;
#(
   parameter int unsigned PRE_RATIO = 8,
   parameter int unsigned REG_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_en,
   input  logic [REG_W-1:0] cfg_wr_data,
   output logic [REG_W-1:0] cfg_rd_data,
   output logic             cfg_loaded,
   output logic             tick,
   input  logic             cmd_launch,
   input  logic             buf_empty,
   output logic             cmd_accept,
   output logic             acc_err
);
   localparam int unsigned CFG_W = $bits(fd_cfg_t);

   generate
      if (REG_W != CFG_W + 1) begin : g_bad_width
         $error("flash_tick_divider: REG_W must equal divide bits + 2");
      end
   endgenerate

   fd_cfg_t cfg, wr_cfg;
   logic    pre_stb;

   assign wr_cfg = fd_cfg_t'(cfg_wr_data[CFG_W-1:0]);

   fd_cfg_reg u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr_en),
      .wr_cfg (wr_cfg),
      .cfg    (cfg),
      .loaded (cfg_loaded)
   );

   fd_prescaler #(.PRE_RATIO(PRE_RATIO)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (cfg_wr_en),
      .run     (cfg_loaded),
      .pre_sel (cfg.pre_sel),
      .stb     (pre_stb)
   );

   fd_main_count #(.DIV_W(DIV_BITS)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (cfg_wr_en),
      .stb   (pre_stb),
      .div   (cfg.div),
      .tick  (tick)
   );

   fd_launch_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (cmd_launch),
      .loaded    (cfg_loaded),
      .buf_empty (buf_empty),
      .accept    (cmd_accept),
      .err       (acc_err)
   );

   assign cfg_rd_data = {cfg_loaded, cfg};
endmodule

// File: rtl/fd_checker.sv
module fd_checker #(
   parameter int unsigned REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr_en,
   input logic [REG_W-1:0] cfg_rd_data,
   input logic             cfg_loaded,
   input logic             tick,
   input logic             cmd_launch,
   input logic             buf_empty,
   input logic             cmd_accept,
   input logic             acc_err
);
   AST_WRITE_SETS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_en |=> cfg_loaded); // R2
   AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_loaded |=> cfg_loaded); // R2
   AST_RD_FLAG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_data[REG_W-1] == cfg_loaded); // R2
   AST_QUIET_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_en |=> !tick); // R5
   AST_NO_TICK_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_loaded |-> !tick); // R6
   AST_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_launch && cfg_loaded && buf_empty) |=> (cmd_accept && !acc_err)); // R7
   AST_REFUSE_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_launch && !cfg_loaded) |=> (acc_err && !cmd_accept)); // R8
   AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_launch && !buf_empty) |=> (acc_err && !cmd_accept)); // R9
   AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_launch |=> (!cmd_accept && !acc_err)); // R10
endmodule

bind flash_tick_divider fd_checker #(.REG_W(REG_W)) u_fd_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_wr_en   (cfg_wr_en),
   .cfg_rd_data (cfg_rd_data),
   .cfg_loaded  (cfg_loaded),
   .tick        (tick),
   .cmd_launch  (cmd_launch),
   .buf_empty   (buf_empty),
   .cmd_accept  (cmd_accept),
   .acc_err     (acc_err)
);

// File: tb/test_flash_tick_divider.sv
module test_flash_tick_divider;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr_en = 1'b0;
   logic [7:0] cfg_wr_data = '0;
   logic [7:0] cfg_rd_data;
   logic       cfg_loaded;
   logic       tick;
   logic       cmd_launch = 1'b0;
   logic       buf_empty = 1'b0;
   logic       cmd_accept;
   logic       acc_err;

   int n_cmp = 0;
   int n_bad = 0;
   logic m_loaded = 1'b0;

   always #2.5 clk = ~clk;

   flash_tick_divider i_flash_tick_divider (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_data(cfg_rd_data), .cfg_loaded(cfg_loaded), .tick(tick),
      .cmd_launch(cmd_launch), .buf_empty(buf_empty),
      .cmd_accept(cmd_accept), .acc_err(acc_err)
   );

   function automatic int period_of(input logic [7:0] v);
      return (1 + 7 * int'(v[6])) * (int'(v[5:0]) + 1);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // drive at negedge, sample at the next negedge
   task automatic do_write(input logic [7:0] v);
      int n;
      cfg_wr_en   = 1'b1;
      cfg_wr_data = v;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      m_loaded  = 1'b1;
      check("R2", cfg_loaded, 1);
      check("R3", cfg_rd_data, {1'b1, v[6:0]});
      check("R5", tick, 0);
      n = period_of(v);
      for (int m = 1; m <= 2 * n; m++) begin
         @(negedge clk);
         check((m <= n) ? "R5" : "R4", tick, (m % n) == 0);
      end
   endtask

   task automatic do_launch(input logic empty);
      logic exp_ok;
      exp_ok     = m_loaded && empty;
      cmd_launch = 1'b1;
      buf_empty  = empty;
      @(negedge clk);
      cmd_launch = 1'b0;
      check(!m_loaded ? "R8" : (!empty ? "R9" : "R7"), {cmd_accept, acc_err}, {exp_ok, !exp_ok});
      @(negedge clk);
      check("R10", {cmd_accept, acc_err}, 2'b00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1", {cfg_loaded, cfg_rd_data, tick, cmd_accept, acc_err}, '0);
      rst_n = 1'b1;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         check("R6", tick, 0);
      end
      do_launch(1'b1);   // R8 never written
      check("R1", cfg_loaded, 0);
      do_write(8'h00);   // fastest rate
      do_write(8'h54);   // divide by 168
      do_write(8'h80);   // bit 7 ignored, R3
      do_write(8'h7F);   // slowest rate
      do_write(8'h40);
      do_launch(1'b1);   // R7
      do_launch(1'b0);   // R9
      for (int k = 0; k < 25; k++) begin
         do_write(8'($urandom));
         do_launch(1'($urandom));
         for (int j = 0; j < int'($urandom_range(5, 0)); j++) begin
            @(negedge clk);
            check("R10", {cmd_accept, acc_err}, 2'b00);
         end
      end
      // write in mid-period restarts phase, R5
      cfg_wr_en = 1'b1; cfg_wr_data = 8'h43;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      repeat (13) @(negedge clk);
      do_write(8'h45);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule